// File: doc/BRIEF.md
# External-Master Halfword Read Port with Line Buffer

This block lets a bus master outside the chip read internal memory while the host processor is held off the bus. While the hold input is high, the master drives chip-select low with the direction line set to read and places a halfword address on the bus. The block returns the 16-bit halfword at that address. The byte-enable inputs play no part in a read.

The block keeps one 128-bit line buffer with a valid flag and a tag. A read whose line is already in the buffer is answered from it one clock after the strobe is sampled. The internal memory is not touched. A read to any other line starts a fetch of the whole aligned line through a request/acknowledge handshake. A wait flag stays high for the whole fetch. Once started, a fetch cannot be aborted. The buffer is invalidated whenever hold is low, so each hold period starts with an empty buffer.

Top module: `xm_line_reader`

## Requirements
- R1: A read is recognised only at a clock edge where `hold_i`=1, `cs_n_i`=0 and `rd_i`=1. Any other combination raises neither `mreq_o` nor `pend_o`, and `rdata_o` keeps its value.
- R2: On a recognised read that misses the buffer, `mreq_o` rises in the following cycle. `mline_o` then equals the address bits above the low three bits, and both stay unchanged until `mack_i` is sampled high.
- R3: The returned halfword is bits [16k+15:16k] of the 128-bit line, where k = `addr_i`[2:0]. The value of `be_i` has no effect.
- R4: During a miss, `pend_o` is high from the cycle after the strobe is sampled until the edge that samples `mack_i`=1. It is low from the next cycle onward, and `rdata_o` is then valid.
- R5: A read that hits a valid buffered line with a matching tag never raises `pend_o` or `mreq_o`. Its data is on `rdata_o` one clock after the strobe is sampled.
- R6: Releasing `cs_n_i` while `pend_o` is high does not abort the fetch. The line is still loaded, so a later read of the same line hits.
- R7: One low strobe yields one access. After completion, no new access starts until `cs_n_i` has been seen high, even if the address changes.
- R8: Any cycle with `hold_i`=0 invalidates the buffer, so the next read misses even for the previously buffered line.
- R9: After reset `pend_o`=0, `mreq_o`=0, `rdata_o`=0 and the buffer is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Host held off the bus; external access allowed |
| cs_n_i | input | 1 | Active-low chip-select strobe from the master |
| rd_i | input | 1 | Direction, 1 = read |
| addr_i | input | ADDR_W | Halfword address |
| be_i | input | 2 | Byte enables, ignored for reads |
| rdata_o | output | 16 | Returned halfword |
| pend_o | output | 1 | High while the access is waiting |
| mreq_o | output | 1 | Line fetch request to internal memory |
| mline_o | output | ADDR_W-3 | Line address of the fetch |
| mack_i | input | 1 | Memory acknowledge, one cycle, data valid |
| mdata_i | input | 128 | Line data from memory |

## Verification
Assertions in the RTL check on every cycle that:
- a fetch begins only after a valid strobe;
- the line address stays steady while a fetch is outstanding;
- the wait flag drops right after the acknowledge;
- a hit or a lingering strobe never starts a fetch;
- the buffer is invalid after hold drops.

Only the bench scenarios can show that the returned halfword has the right value. The same holds for whether a later read hits or misses, for the wait length under each memory latency, and for a fetch surviving an early strobe release.

// File: rtl/xm_line_reader.sv
module xm_line_reader #(
  parameter int ADDR_W  = 23,
  parameter int HW_W    = 16,
  parameter int LINE_HW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold_i,
  input  logic                        cs_n_i,
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [HW_W/8-1:0]           be_i,
  output logic [HW_W-1:0]             rdata_o,
  output logic                        pend_o,
  output logic                        mreq_o,
  output logic [ADDR_W-$clog2(LINE_HW)-1:0] mline_o,
  input  logic                        mack_i,
  input  logic [HW_W*LINE_HW-1:0]     mdata_i
);
  localparam int OFF_W  = $clog2(LINE_HW);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = HW_W * LINE_HW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} st_t;

  st_t              st;
  logic             vld;
  logic [TAG_W-1:0] tag, req_tag;
  logic [OFF_W-1:0] req_off;
  logic [LINE_W-1:0] line;
  logic             req, hit, unused_be;

  assign unused_be = ^be_i;
  assign req     = hold_i & ~cs_n_i & rd_i;
  assign hit     = vld & (tag == addr_i[ADDR_W-1:OFF_W]);
  assign pend_o  = (st == S_FETCH);
  assign mreq_o  = (st == S_FETCH);
  assign mline_o = req_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vld     <= 1'b0;
      tag     <= '0;
      req_tag <= '0;
      req_off <= '0;
      line    <= '0;
      rdata_o <= '0;
    end else begin
      if (!hold_i) vld <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          req_tag <= addr_i[ADDR_W-1:OFF_W];
          req_off <= addr_i[OFF_W-1:0];
          if (hit) begin
            rdata_o <= line[addr_i[OFF_W-1:0]*HW_W +: HW_W];
            st      <= S_DONE;
          end else begin
            st      <= S_FETCH;
          end
        end
        S_FETCH: if (mack_i) begin
          line    <= mdata_i;
          tag     <= req_tag;
          vld     <= hold_i;
          rdata_o <= mdata_i[req_off*HW_W +: HW_W];
          st      <= S_DONE;
        end
        S_DONE: if (cs_n_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  a_r1_fetch_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreq_o) |-> $past(hold_i && !cs_n_i && rd_i));
  // R2
  a_r2_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_o && !mack_i) |=> (mreq_o && $stable(mline_o)));
  // R4
  a_r4_wait_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && mack_i) |=> (!pend_o && !mreq_o));
  // R5
  a_r5_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && hit) |=> !mreq_o);
  // R7
  a_r7_one_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !cs_n_i) |=> !mreq_o);
  // R8
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && st != S_FETCH) |=> !vld);
endmodule

// File: tb/xm_line_reader_tb.sv
module xm_line_reader_tb;
  localparam int AW = 23;
  logic clk = 0, rst_n = 0;
  logic hold = 0, cs_n = 1, rd = 0, mack = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] be = '0;
  logic [15:0] rdata;
  logic pend, mreq;
  logic [AW-4:0] mline;
  logic [127:0] mdata = '0;
  int checks = 0, fails = 0, lat = 3, cnt = 0, cycles = 0;
  bit mvld = 0;
  int mtag = 0;

  always #10 clk = ~clk;

  xm_line_reader #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .cs_n_i(cs_n), .rd_i(rd),
    .addr_i(addr), .be_i(be), .rdata_o(rdata), .pend_o(pend), .mreq_o(mreq),
    .mline_o(mline), .mack_i(mack), .mdata_i(mdata));

  function automatic logic [15:0] hw_val(int a);
    logic [31:0] v;
    v = a * 40503;
    return v[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [127:0] line_of(int t);
    logic [127:0] l;
    for (int i = 0; i < 8; i++) l[i*16 +: 16] = hw_val(t*8 + i);
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin mack <= 0; cnt = 0; end
    else if (mreq && !mack) begin
      cnt++;
      if (cnt == lat - 1) begin mack <= 1; mdata <= line_of(int'(mline)); end
    end else begin mack <= 0; cnt = 0; end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_read(int a, bit early, bit linger);
    bit ehit;
    ehit = mvld && (mtag == a / 8) && hold;
    addr = AW'(a); cs_n = 0; rd = 1; be = 2'(a + 1);
    @(negedge clk);
    if (ehit) begin
      chk(pend == 0, "R5 hit wait", 32'(pend), 0);
      chk(mreq == 0, "R5 hit no fetch", 32'(mreq), 0);
    end else begin
      for (int i = 0; i < lat; i++) begin
        chk(pend == 1, "R4 wait high", 32'(pend), 1);
        chk(mreq == 1 && int'(mline) == a / 8, "R2 fetch line", 32'(mline), 32'(a / 8));
        if (early && i == 0) cs_n = 1;
        @(negedge clk);
      end
      chk(pend == 0, early ? "R6 fetch done" : "R4 wait low", 32'(pend), 0);
      mvld = hold; mtag = a / 8;
    end
    chk(rdata == hw_val(a), "R3 halfword", 32'(rdata), 32'(hw_val(a)));
    if (linger) begin
      addr = AW'(a + 512);
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk(mreq == 0 && pend == 0, "R7 one access per strobe", 32'(mreq), 0);
      end
    end
    cs_n = 1;
    @(negedge clk);
    chk(pend == 0 && mreq == 0, "R4 idle", 32'(pend), 0);
  endtask

  task automatic ignored(int a, bit h, bit r);
    logic [15:0] prev;
    prev = rdata;
    hold = h; rd = r; addr = AW'(a); cs_n = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(pend == 0 && mreq == 0, "R1 no access", 32'(mreq), 0);
      chk(rdata == prev, "R1 data kept", 32'(rdata), 32'(prev));
    end
    cs_n = 1; hold = 1; rd = 1;
    if (!h) mvld = 0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk(pend == 0 && mreq == 0, "R9 reset outputs", 32'(pend), 0);
    chk(rdata == 0, "R9 reset data", 32'(rdata), 0);
    @(negedge clk); rst_n = 1; hold = 1;
    @(negedge clk);
    lat = 3; do_read(37, 0, 0);
    do_read(38, 0, 0);
    do_read(32, 0, 0);
    do_read(39, 0, 1);
    lat = 7; do_read(200, 1, 0);
    do_read(205, 0, 0);
    lat = 5; do_read(37, 0, 0);
    do_read(36, 0, 0);
    ignored(44, 0, 1);
    lat = 4; do_read(37, 0, 0);
    ignored(37, 1, 0);
    do_read(34, 0, 0);
    hold = 0; @(negedge clk); mvld = 0; hold = 1; @(negedge clk);
    lat = 6; do_read(35, 0, 0);
    do_read(1000, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule